// File: doc/BRIEF.md
# Typed Nonce Result Reporter

This block sits between a hashing core and a serial link to the host. It takes two kinds of event from the device side. The first is a found nonce, given as a one-cycle strobe with a 32-bit value. The second is a work-accepted strobe. The block turns each event into a typed packet and sends it out over an 8N1 UART transmitter. Each packet opens with a type byte, so the host can tell a nonce report from a work-accepted marker. Both kinds of event go through one ordered queue. A nonce that reaches the host before a marker belongs to the previous work unit, and a nonce that arrives after it belongs to the new one.

The block never stalls the hashing side: it has no ready signal, and it can take a strobe on every cycle. A small queue absorbs bursts while the line is busy. When the queue cannot hold a new nonce, that nonce is discarded and a sticky overflow flag is raised. A work-accepted marker is never discarded. If there is no room for it, it replaces the most recently queued entry. The bit time is `CLK_HZ / BAUD` clock cycles. The defaults give 115200 baud from a 125 MHz clock.

Top module: `result_reporter`

## Requirements
- R1: After reset the overflow output is 0. The tx line is 1 whenever no byte is being sent.
- R2: Each byte is framed as follows, and every bit lasts `CLK_HZ/BAUD` cycles:
  - one start bit at 0;
  - eight data bits, least significant bit first;
  - one stop bit at 1.

  The start bit of the next byte may follow the stop bit directly.
- R3: A found nonce is sent as five bytes: the type byte 0x01, then the four nonce bytes, most significant byte first.
- R4: A work-accepted event is sent as the single byte 0x02, with no payload.
- R5: Packets leave in the order in which their events arrived. When both strobes are high in the same cycle, the nonce packet is sent before the work-accepted packet.
- R6: The queue holds up to 4 events behind the packet being transmitted. A burst of 5 events on consecutive cycles, or with any spacing, loses none of them and leaves overflow at 0.
- R7: If a nonce strobe arrives while the queue holds 4 events and no entry leaves it in that cycle, the nonce is discarded and overflow goes to 1.
- R8: A work-accepted strobe is never discarded. If the queue has no room, the marker replaces the newest queued entry. When that entry was a nonce, overflow goes to 1.
- R9: Once overflow is 1, it stays 1 until reset, whatever traffic follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| found_valid | input | 1 | One-cycle strobe: a nonce was found |
| found_nonce | input | 32 | Nonce value, sampled when found_valid is high |
| work_accepted | input | 1 | One-cycle strobe: new work was taken |
| tx | output | 1 | Serial line to the host, idle high |
| overflow | output | 1 | Sticky flag: a nonce was lost |

## Verification
The bound checker watches properties that hold on every cycle:
- the line idles high whenever the transmitter is free;
- the line holds steady within a bit time;
- the queue occupancy stays within its depth;
- a discard into a full queue raises the flag;
- a work marker always leaves the queue non-empty;
- the flag is sticky.

Properties that depend on sequences of events can only be shown by the bench's scenarios, which decode the serial line independently. These are the packet contents, the byte order, the order of events across packets, the ordering rule for simultaneous strobes, and which entry a marker replaces when the queue is full.

// File: rtl/rr_pkg.sv
package rr_pkg;

    localparam int NONCE_W     = 32;
    localparam int NONCE_BYTES = NONCE_W / 8;

    typedef enum logic [7:0] {
        PKT_NONCE = 8'h01,
        PKT_WORK  = 8'h02
    } rr_pkt_e;

    typedef struct packed {
        logic               is_work;
        logic [NONCE_W-1:0] nonce;
    } rr_entry_t;

endpackage

// File: rtl/rr_event_queue.sv
module rr_event_queue
    import rr_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       nonce_push,
    input  logic [NONCE_W-1:0]         nonce_val,
    input  logic                       work_push,
    input  logic                       pop,
    output rr_entry_t                  head,
    output logic                       head_valid,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       ovf
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        rr_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]         wr;
        logic [PW-1:0]         rd;
        logic [CW-1:0]         cnt;
        logic                  ovf;
    } q_state_t;

    q_state_t state_d, state_q;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
        return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
    endfunction

    always_comb begin
        state_d = state_q;
        // Departure first: it frees a slot for arrivals in the same cycle.
        if (pop && state_q.cnt != '0) begin
            state_d.rd  = ptr_inc(state_q.rd);
            state_d.cnt = state_d.cnt - 1'b1;
        end
        // A nonce arriving with a marker is ordered ahead of it.
        if (nonce_push) begin
            if (state_d.cnt < CW'(DEPTH)) begin
                state_d.mem[state_d.wr] = '{is_work: 1'b0, nonce: nonce_val};
                state_d.wr              = ptr_inc(state_d.wr);
                state_d.cnt             = state_d.cnt + 1'b1;
            end else begin
                state_d.ovf = 1'b1;
            end
        end
        if (work_push) begin
            if (state_d.cnt < CW'(DEPTH)) begin
                state_d.mem[state_d.wr] = '{is_work: 1'b1, nonce: '0};
                state_d.wr              = ptr_inc(state_d.wr);
                state_d.cnt             = state_d.cnt + 1'b1;
            end else begin
                if (!state_d.mem[ptr_dec(state_d.wr)].is_work) begin
                    state_d.ovf = 1'b1;
                end
                state_d.mem[ptr_dec(state_d.wr)] = '{is_work: 1'b1, nonce: '0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign head       = state_q.mem[state_q.rd];
    assign head_valid = (state_q.cnt != '0);
    assign count      = state_q.cnt;
    assign ovf        = state_q.ovf;

endmodule

// File: rtl/rr_packetizer.sv
module rr_packetizer
    import rr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  rr_entry_t head,
    input  logic      head_valid,
    output logic      pop,
    output logic      byte_valid,
    output logic [7:0] byte_data,
    input  logic      byte_ready
);

    localparam int IW = $clog2(NONCE_BYTES + 1);

    typedef struct packed {
        logic          busy;
        rr_entry_t     ent;
        logic [IW-1:0] idx;
    } pk_state_t;

    pk_state_t state_d, state_q;
    logic      last_byte;
    logic      fire;

    always_comb begin
        if (state_q.idx == '0) begin
            byte_data = state_q.ent.is_work ? 8'(PKT_WORK) : 8'(PKT_NONCE);
        end else begin
            byte_data = 8'(state_q.ent.nonce >> (8 * (NONCE_BYTES - int'(state_q.idx))));
        end
    end

    assign last_byte  = state_q.ent.is_work ? (state_q.idx == '0)
                                            : (state_q.idx == IW'(NONCE_BYTES));
    assign byte_valid = state_q.busy;
    assign fire       = state_q.busy && byte_ready;
    assign pop        = !state_q.busy && head_valid;

    always_comb begin
        state_d = state_q;
        if (pop) begin
            state_d.busy = 1'b1;
            state_d.ent  = head;
            state_d.idx  = '0;
        end else if (fire) begin
            if (last_byte) state_d.busy = 1'b0;
            else           state_d.idx  = state_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/rr_uart_tx.sv
module rr_uart_tx #(
    parameter int CLKS_PER_BIT = 1085
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       tx,
    output logic       busy_o,
    output logic       hold_o
);

    localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;

    typedef struct packed {
        logic             busy;
        logic             line;
        logic [8:0]       shreg;
        logic [3:0]       left;
        logic [CNT_W-1:0] cnt;
    } tx_state_t;

    localparam tx_state_t IDLE_ST = '{busy: 1'b0, line: 1'b1, shreg: '1, left: '0, cnt: '0};

    tx_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!state_q.busy) begin
            if (in_valid) begin
                state_d.busy  = 1'b1;
                state_d.line  = 1'b0;
                state_d.shreg = {1'b1, in_data};
                state_d.left  = 4'd9;
                state_d.cnt   = CNT_W'(CLKS_PER_BIT - 1);
            end
        end else if (state_q.cnt != '0) begin
            state_d.cnt = state_q.cnt - 1'b1;
        end else if (state_q.left == '0) begin
            state_d.busy = 1'b0;
        end else begin
            state_d.line  = state_q.shreg[0];
            state_d.shreg = {1'b1, state_q.shreg[8:1]};
            state_d.left  = state_q.left - 1'b1;
            state_d.cnt   = CNT_W'(CLKS_PER_BIT - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDLE_ST;
        else        state_q <= state_d;
    end

    assign in_ready = !state_q.busy;
    assign tx       = state_q.line;
    assign busy_o   = state_q.busy;
    assign hold_o   = (state_q.cnt != '0);

endmodule

// File: rtl/result_reporter.sv
module result_reporter
    import rr_pkg::*;
#(
    parameter int CLK_HZ = 125_000_000,
    parameter int BAUD   = 115_200,
    parameter int DEPTH  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        found_valid,
    input  logic [31:0] found_nonce,
    input  logic        work_accepted,
    output logic        tx,
    output logic        overflow
);

    localparam int CLKS_PER_BIT = CLK_HZ / BAUD;
    localparam int CW           = $clog2(DEPTH + 1);

    rr_entry_t     q_head;
    logic          q_valid;
    logic          q_pop;
    logic [CW-1:0] q_count;
    logic          b_valid;
    logic          b_ready;
    logic [7:0]    b_data;
    logic          tx_busy;
    logic          tx_hold;

    rr_event_queue #(.DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .nonce_push (found_valid),
        .nonce_val  (found_nonce),
        .work_push  (work_accepted),
        .pop        (q_pop),
        .head       (q_head),
        .head_valid (q_valid),
        .count      (q_count),
        .ovf        (overflow)
    );

    rr_packetizer u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .head       (q_head),
        .head_valid (q_valid),
        .pop        (q_pop),
        .byte_valid (b_valid),
        .byte_data  (b_data),
        .byte_ready (b_ready)
    );

    rr_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (b_valid),
        .in_data  (b_data),
        .in_ready (b_ready),
        .tx       (tx),
        .busy_o   (tx_busy),
        .hold_o   (tx_hold)
    );

endmodule

// File: rtl/rr_checker.sv
module rr_checker #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       found_valid,
    input logic                       work_accepted,
    input logic                       tx,
    input logic                       overflow,
    input logic [$clog2(DEPTH+1)-1:0] q_count,
    input logic                       q_pop,
    input logic                       tx_busy,
    input logic                       tx_hold
);

    assert_line_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx);

    assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && tx_hold) |=> $stable(tx));

    assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= ($clog2(DEPTH+1))'(DEPTH));

    assert_drop_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (found_valid && q_count == ($clog2(DEPTH+1))'(DEPTH) && !q_pop) |=> overflow);

    assert_work_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        work_accepted |=> (q_count != '0));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

bind result_reporter rr_checker #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .found_valid   (found_valid),
    .work_accepted (work_accepted),
    .tx            (tx),
    .overflow      (overflow),
    .q_count       (q_count),
    .q_pop         (q_pop),
    .tx_busy       (tx_busy),
    .tx_hold       (tx_hold)
);

// File: tb/result_reporter_bench.sv
module result_reporter_bench;

    localparam int CLK_HZ = 125_000_000;
    localparam int BAUD   = 15_625_000;
    localparam int CPB    = CLK_HZ / BAUD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        found_valid = 1'b0;
    logic [31:0] found_nonce = '0;
    logic        work_accepted = 1'b0;
    logic        tx;
    logic        overflow;

    int checks = 0;
    int fails  = 0;

    logic [7:0] rx_q[$];
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    result_reporter #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DEPTH(4)) u_result_reporter (
        .clk           (clk),
        .rst_n         (rst_n),
        .found_valid   (found_valid),
        .found_nonce   (found_nonce),
        .work_accepted (work_accepted),
        .tx            (tx),
        .overflow      (overflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Expected packet bytes, built from the requirements: R3 and R4.
    function automatic void expect_nonce(input logic [31:0] n);
        exp_q.push_back(8'h01);
        for (int i = 3; i >= 0; i--) exp_q.push_back(n[8*i +: 8]);
    endfunction

    function automatic void expect_work();
        exp_q.push_back(8'h02);
    endfunction

    // Independent serial decoder (R2): mid-bit sampling, framing checked.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx == 1'b0) begin
                logic [7:0] b;
                repeat (CPB/2 - 1) @(negedge clk);
                check("R2 start bit", 32'(tx), 32'd0);
                for (int i = 0; i < 8; i++) begin
                    repeat (CPB) @(negedge clk);
                    b[i] = tx;
                end
                repeat (CPB) @(negedge clk);
                check("R2 stop bit", 32'(tx), 32'd1);
                rx_q.push_back(b);
            end
        end
    end

    task automatic wait_drain();
        int idle = 0;
        while (idle < 15*CPB) begin
            @(negedge clk);
            if (tx) idle++; else idle = 0;
        end
    endtask

    task automatic compare_stream(input string req);
        check({req, " byte count"}, 32'(rx_q.size()), 32'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
            check(req, 32'(rx_q[i]), 32'(exp_q[i]));
        rx_q.delete();
        exp_q.delete();
    endtask

    // Drive one cycle of strobes, set up at the falling edge.
    task automatic drive(input logic nv, input logic [31:0] n, input logic wv);
        @(negedge clk);
        found_valid   = nv;
        found_nonce   = n;
        work_accepted = wv;
    endtask

    task automatic release_inputs();
        @(negedge clk);
        found_valid   = 1'b0;
        work_accepted = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        do_reset();
        // R1: reset state and idle line
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check("R1 idle tx", 32'(tx), 32'd1);
        end
        check("R1 overflow after reset", 32'(overflow), 32'd0);

        // R3: directed single nonce with distinct bytes
        drive(1'b1, 32'h12345678, 1'b0); expect_nonce(32'h12345678);
        release_inputs();
        wait_drain();
        compare_stream("R3 nonce packet");

        // R4: single work marker
        drive(1'b0, '0, 1'b1); expect_work();
        release_inputs();
        wait_drain();
        compare_stream("R4 work packet");

        // R5: simultaneous strobes, nonce goes first
        drive(1'b1, 32'hCAFEBABE, 1'b1); expect_nonce(32'hCAFEBABE); expect_work();
        release_inputs();
        wait_drain();
        compare_stream("R5 same-cycle order");

        // R5/R6: random bursts of at most 5 entries
        for (int burst = 0; burst < 20; burst++) begin
            int room = 1 + int'($urandom % 5);
            while (room > 0) begin
                int kind = int'($urandom % 4);
                logic [31:0] n = $urandom;
                if (kind == 3 && room >= 2) begin
                    drive(1'b1, n, 1'b1); expect_nonce(n); expect_work(); room -= 2;
                end else if (kind == 2) begin
                    drive(1'b0, '0, 1'b1); expect_work(); room -= 1;
                end else begin
                    drive(1'b1, n, 1'b0); expect_nonce(n); room -= 1;
                end
                if ($urandom % 2 == 1) begin
                    release_inputs();
                    repeat (int'($urandom % 3)) @(negedge clk);
                end
            end
            release_inputs();
            wait_drain();
            compare_stream("R5 R6 random burst order");
        end
        check("R6 no overflow within capacity", 32'(overflow), 32'd0);

        // R7: six nonces back to back, the sixth is lost
        for (int i = 0; i < 6; i++) begin
            logic [31:0] n = 32'hA0000000 + 32'(i);
            drive(1'b1, n, 1'b0);
            if (i < 5) expect_nonce(n);
        end
        release_inputs();
        check("R7 overflow raised", 32'(overflow), 32'd1);
        wait_drain();
        compare_stream("R7 dropped nonce");

        // R9: flag survives normal traffic
        drive(1'b1, 32'h0BADF00D, 1'b0); expect_nonce(32'h0BADF00D);
        release_inputs();
        wait_drain();
        compare_stream("R9 traffic after overflow");
        check("R9 overflow sticky", 32'(overflow), 32'd1);

        do_reset();
        @(negedge clk);
        check("R1 R9 overflow cleared by reset", 32'(overflow), 32'd0);

        // R8: queue full, marker replaces the newest nonce
        for (int i = 0; i < 5; i++) begin
            logic [31:0] n = 32'hB0000000 + 32'(i);
            drive(1'b1, n, 1'b0);
            if (i < 4) expect_nonce(n);
        end
        drive(1'b0, '0, 1'b1); expect_work();
        release_inputs();
        check("R8 overflow on replaced nonce", 32'(overflow), 32'd1);
        wait_drain();
        compare_stream("R8 marker kept");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190_000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule